// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces, one per clock, the column addresses of a single SDRAM burst. A controller presents a starting column together with a length code and an ordering bit, and pulses a start input. From the following cycle the block emits one column per clock with a valid flag, and marks the final column of a fixed-length burst with a last flag. A stop input cuts a burst short, and it is the only way to end a full-page burst.

Two orderings are offered. Sequential counting rises from the start column and wraps inside the aligned group of columns the burst covers. Interleaved counting XORs the start offset with the beat number inside that group. In full-page mode the count runs across the whole 512-column page, wraps from its top back to zero, and continues until it is stopped. Length codes with no defined meaning are rejected with a one-cycle error flag.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `err_o` are 0.
- R2: Length code `len_code_i` 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. The first beat appears in the cycle after the clock edge that samples `start_i`, and `valid_o` stays high for exactly that many cycles.
- R3: With `btype_i`=0 the order is sequential. The low bits count upward from the start column and wrap inside the aligned group (length 8, start offset 3: 3,4,5,6,7,0,1,2).
- R4: With `btype_i`=1 the order is interleaved. The low bits are the start offset XOR the beat number (length 8, start offset 3: 3,2,1,0,7,6,5,4).
- R5: Column bits above the group width keep their starting values for the whole burst.
- R6: Code 111 with `btype_i`=0 is full page. The column rises by one each beat, wraps from 511 to 0, and continues until stopped.
- R7: `last_o` is high with the final beat of a fixed-length burst, only while `valid_o` is high, and never during a full-page burst.
- R8: `stop_i` sampled while a beat is shown ends the burst. `valid_o` is 0 in the next cycle.
- R9: Codes 100, 101 and 110, and code 111 with `btype_i`=1, raise `err_o` for one cycle after the start edge. They start no burst and leave any running burst undisturbed.
- R10: A valid start during a running burst abandons it, and the new first beat appears in the next cycle. When start and stop arrive together, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst with the presented settings |
| len_code_i | input | 3 | Burst length code |
| btype_i | input | 1 | Order: 0 sequential, 1 interleaved |
| col_i | input | COL_W | Starting column |
| stop_i | input | 1 | End the current burst |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | `col_o` holds a burst beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | Previous start carried an illegal mode |

## Verification
The start input and the burst-ending paths (a stop, or the natural end after the last beat) can fall on the same edge. The bench raises a new start together with stop in the middle of a length-8 burst and expects the new burst's first column in the next cycle, with no idle gap. It also issues a rejected start during a running burst, and requires that the old burst carries on at its next expected column while `err_o` pulses.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam logic [2:0] LEN_ONE   = 3'b000;
  localparam logic [2:0] LEN_TWO   = 3'b001;
  localparam logic [2:0] LEN_FOUR  = 3'b010;
  localparam logic [2:0] LEN_EIGHT = 3'b011;
  localparam logic [2:0] LEN_PAGE  = 3'b111;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       code_i,
  input  logic             il_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o,
  output logic             bad_o
);
  always_comb begin
    mask_o = '0;
    page_o = 1'b0;
    bad_o  = 1'b0;
    unique case (code_i)
      LEN_ONE:   mask_o = COL_W'(0);
      LEN_TWO:   mask_o = COL_W'(1);
      LEN_FOUR:  mask_o = COL_W'(3);
      LEN_EIGHT: mask_o = COL_W'(7);
      LEN_PAGE: begin
        mask_o = '1;
        page_o = 1'b1;
        bad_o  = il_i;
      end
      default:   bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/bcg_col_order.sv
module bcg_col_order #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             il_i,
  input  logic [COL_W-1:0] idx_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum_w;
  logic [COL_W-1:0] xor_w;

  assign sum_w = base_i + idx_i;
  assign xor_w = base_i ^ idx_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? (il_i ? xor_w[b] : sum_w[b]) : base_i[b];
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [2:0]       len_code_i,
  input  logic             btype_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic             dec_bad;

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             il_q;
  logic             fp_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] nxt_idx;
  logic [COL_W-1:0] nxt_col;

  bcg_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i (len_code_i),
    .il_i   (btype_i),
    .mask_o (dec_mask),
    .page_o (dec_page),
    .bad_o  (dec_bad)
  );

  assign nxt_idx = cnt_q + 1'b1;

  bcg_col_order #(.COL_W(COL_W)) u_ord (
    .base_i (base_q),
    .mask_i (mask_q),
    .il_i   (il_q),
    .idx_i  (nxt_idx),
    .col_o  (nxt_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      mask_q  <= '0;
      il_q    <= 1'b0;
      fp_q    <= 1'b0;
      cnt_q   <= '0;
      col_o   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      err_o <= start_i & dec_bad;
      if (start_i && !dec_bad) begin
        base_q  <= col_i;
        mask_q  <= dec_mask;
        il_q    <= btype_i;
        fp_q    <= dec_page;
        cnt_q   <= '0;
        col_o   <= col_i;
        valid_o <= 1'b1;
        last_o  <= !dec_page && (dec_mask == '0);
      end else if (valid_o && (stop_i || last_o)) begin
        valid_o <= 1'b0;
        last_o  <= 1'b0;
      end else if (valid_o) begin
        cnt_q  <= nxt_idx;
        col_o  <= nxt_col;
        last_o <= !fp_q && (nxt_idx == mask_q);
      end
    end
  end
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             err_o,
  input logic [COL_W-1:0] mask_q,
  input logic             fp_q
);
  a_r7_last_in_burst: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  a_r7_no_last_page: assert property (@(posedge clk) disable iff (rst)
    fp_q |-> !last_o);

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (rst)
    (valid_o && stop_i && !start_i) |=> !valid_o);

  a_r2_keeps_going: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !stop_i && !start_i) |=> valid_o);

  a_r5_high_bits_fixed: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !stop_i && !start_i) |=>
      (((col_o ^ $past(col_o)) & ~mask_q) == '0));

  a_r6_page_step: assert property (@(posedge clk) disable iff (rst)
    (fp_q && valid_o && !stop_i && !start_i) |=>
      (col_o == COL_W'($past(col_o) + 1'b1)));

  a_r9_err_after_start: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(start_i));
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .stop_i  (stop_i),
  .col_o   (col_o),
  .valid_o (valid_o),
  .last_o  (last_o),
  .err_o   (err_o),
  .mask_q  (mask_q),
  .fp_q    (fp_q)
);

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;
  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [2:0]       len_code_i = 3'b000;
  logic             btype_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;
  logic             err_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .len_code_i(len_code_i),
    .btype_i(btype_i), .col_i(col_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int c, input int len, input bit il, input int k);
    int m = len - 1;
    if (il) return (c & ~m) | ((c ^ k) & m);
    return ((c & ~m) | ((c + k) & m)) & 511;
  endfunction

  task automatic pulse_start(input logic [2:0] code, input bit il, input int c);
    start_i = 1'b1; len_code_i = code; btype_i = il; col_i = COL_W'(c);
  endtask

  task automatic run_burst(input string req, input logic [2:0] code,
                           input bit il, input int c, input int len);
    @(negedge clk); pulse_start(code, il, c);
    @(negedge clk); start_i = 1'b0;
    for (int k = 0; k < len; k++) begin
      chk({req, " valid"}, valid_o, 1);
      chk({req, " col"}, col_o, exp_col(c, len, il, k));
      chk("R7 last", last_o, (k == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk({req, " end"}, valid_o, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", valid_o, 0);
    chk("R1 last", last_o, 0);
    chk("R1 err", err_o, 0);
  endtask

  task automatic t_page();
    @(negedge clk); pulse_start(3'b111, 1'b0, 509);
    @(negedge clk); start_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk("R6 col", col_o, (509 + k) % 512);
      chk("R6 valid", valid_o, 1);
      chk("R7 no last in page", last_o, 0);
      if (k == 5) stop_i = 1'b1;
      @(negedge clk);
    end
    stop_i = 1'b0;
    chk("R8 stop ends page", valid_o, 0);
  endtask

  task automatic t_stop_fixed();
    @(negedge clk); pulse_start(3'b011, 1'b0, 8'h40);
    @(negedge clk); start_i = 1'b0;
    chk("R8 beat0", col_o, 'h40);
    stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    chk("R8 stop fixed", valid_o, 0);
    chk("R8 no last", last_o, 0);
  endtask

  task automatic t_reserved_idle(input logic [2:0] code, input bit il);
    @(negedge clk); pulse_start(code, il, 5);
    @(negedge clk); start_i = 1'b0;
    chk("R9 err", err_o, 1);
    chk("R9 no burst", valid_o, 0);
    @(negedge clk);
    chk("R9 err one cycle", err_o, 0);
    chk("R9 still idle", valid_o, 0);
  endtask

  task automatic t_reserved_busy();
    @(negedge clk); pulse_start(3'b011, 1'b0, 'h20);
    @(negedge clk); start_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (k == 2) chk("R9 err during burst", err_o, 1);
      chk("R9 burst undisturbed", col_o, 'h20 + k);
      chk("R9 valid kept", valid_o, 1);
      if (k == 1) pulse_start(3'b101, 1'b0, 'h1FF);
      @(negedge clk);
      start_i = 1'b0;
    end
    chk("R9 burst ends", valid_o, 0);
  endtask

  task automatic t_restart();
    @(negedge clk); pulse_start(3'b011, 1'b0, 'h100);
    @(negedge clk); start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R10 old col", col_o, 'h100 + k);
      if (k == 2) begin
        pulse_start(3'b010, 1'b1, 'h45);
        stop_i = 1'b1;
      end
      @(negedge clk);
    end
    start_i = 1'b0; stop_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R10 new valid", valid_o, 1);
      chk("R10 new col", col_o, exp_col('h45, 4, 1'b1, k));
      chk("R10 new last", last_o, (k == 3) ? 1 : 0);
      @(negedge clk);
    end
    chk("R10 end", valid_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    run_burst("R2 len1", 3'b000, 1'b0, 'h77, 1);
    run_burst("R2 len2", 3'b001, 1'b1, 'h13, 2);
    run_burst("R3 seq8", 3'b011, 1'b0, 'h03, 8);
    run_burst("R4 il8", 3'b011, 1'b1, 'hF3, 8);
    run_burst("R5 seq4 high bits", 3'b010, 1'b0, 'h1A6, 4);
    run_burst("R5 il4 high bits", 3'b010, 1'b1, 'h0BD, 4);
    t_page();
    t_stop_fixed();
    t_reserved_idle(3'b100, 1'b0);
    t_reserved_idle(3'b110, 1'b0);
    t_reserved_idle(3'b111, 1'b1);
    t_reserved_busy();
    t_restart();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule